// File: doc/BRIEF.md
# One-Time Protection Register Programmer

This block holds a 64-bit one-time-programmable protection register, split into four 16-bit segments, plus a lock word that protects each segment from further change. A host drives it through a simple write port. Command bytes on the low byte of the write data select what reads return: the main array (passed through from outside), the protection contents, or an 8-bit status byte. A setup command followed by one address/data write programs one segment.

Programming works like fuse cells. A stored bit can only go from 1 to 0, and the new value is the old value ANDed with the written data. If a write is aimed outside the protection window, or at a segment whose lock bit has been cleared, nothing changes and error bits are raised in the status byte. They stay set until a clear command is written. Reads are combinational from the stored state and the present address, so a command written on one clock edge affects reads right after that edge.

Top module: `otp_prot_reg`

## Requirements
- R1: After reset, reads return `arr_rdata`, every segment word and the lock word read 0xFFFF, and the status byte is 0x80.
- R2: Writing command 0x90 selects the protection read view. At address 0x80 it returns the lock word, with its upper 12 bits read as 1 and bit i as the lock bit of segment i. Addresses 0x81 to 0x84 return segments 0 to 3. Any other address returns 0.
- R3: Writing command 0xFF selects the array view, in which `bus_rdata` follows `arr_rdata`.
- R4: Writing command 0x70 selects the status view, where `bus_rdata` = {8'h00, status}. Status bit 7 (ready) always reads 1, bit 4 is the program error and bit 1 is the lock error.
- R5: Writing 0xC0 arms a program. The next write stores `old & bus_wdata` into the segment at `bus_addr`.
- R6: The write after 0xC0 is always taken as address/data, even when its value is a command code. The read view in use before 0xC0 is then kept.
- R7: A program aimed outside 0x80 to 0x84 (above or below) sets status bit 4 and changes no stored word.
- R8: A program aimed at a segment whose lock bit is 0 sets status bits 4 and 1 and leaves the segment unchanged.
- R9: A program at 0x80 ANDs `bus_wdata[3:0]` into the lock bits. A cleared lock bit can never be set again, and segments whose lock bit is still 1 stay programmable.
- R10: Command 0x50 clears status bits 4 and 1 and leaves the read view unchanged.
- R11: A write of any other byte while no program is armed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Word address for reads and for program writes |
| bus_wdata | input | 16 | Command byte (low byte) or program data |
| arr_rdata | input | 16 | Main array data returned in the array view |
| bus_rdata | output | 16 | Read data of the selected view |

## Verification
The assertions assume that reset is asserted from time zero and that `bus_we`, `bus_addr` and `bus_wdata` hold stable values at every rising edge. They also assume that once a program is armed, its data write is the next write. The bench changes inputs only on falling edges and samples combinational reads one time unit after that. Each program write comes right after its 0xC0 strobe, so the bench never leaves a program armed while it issues unrelated writes.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {
        VIEW_ARRAY  = 2'd0,
        VIEW_PROT   = 2'd1,
        VIEW_STATUS = 2'd2
    } view_e;

    localparam logic [7:0] OP_PROT_VIEW = 8'h90;
    localparam logic [7:0] OP_ARRAY     = 8'hFF;
    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_SETUP     = 8'hC0;
    localparam logic [7:0] OP_CLEAR     = 8'h50;

    localparam int BIT_READY    = 7;
    localparam int BIT_PROG_ERR = 4;
    localparam int BIT_LOCK_ERR = 1;
endpackage

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output view_e      view_o,
    output logic       pgm_stb_o,
    output logic       clr_stb_o
);
    typedef struct packed {
        view_e view;
        logic  armed;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        pgm_stb_o = 1'b0;
        clr_stb_o = 1'b0;
        if (wr_en) begin
            if (s_q.armed) begin
                pgm_stb_o = 1'b1;
                s_d.armed = 1'b0;
            end else begin
                unique case (wr_byte)
                    OP_PROT_VIEW: s_d.view  = VIEW_PROT;
                    OP_ARRAY:     s_d.view  = VIEW_ARRAY;
                    OP_STATUS:    s_d.view  = VIEW_STATUS;
                    OP_SETUP:     s_d.armed = 1'b1;
                    OP_CLEAR:     clr_stb_o = 1'b1;
                    default:      ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{view: VIEW_ARRAY, armed: 1'b0};
        else        s_q <= s_d;
    end

    assign view_o = s_q.view;

    p_setup_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.armed && wr_en) |=> !s_q.armed);
    p_view_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.armed |=> $stable(s_q.view));
endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int          ADDR_W    = 8,
    parameter int          WORD_W    = 16,
    parameter int          N_SEG     = 4,
    parameter int unsigned BASE_ADDR = 'h80
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pgm_stb,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             data,
    output logic [N_SEG-1:0][WORD_W-1:0]  words_o,
    output logic [N_SEG-1:0]              lock_o,
    output logic                          err_prog_o,
    output logic                          err_lock_o
);
    localparam int SEG_IW = (N_SEG > 1) ? $clog2(N_SEG) : 1;
    localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] LAST_X = (ADDR_W+1)'(BASE_ADDR + N_SEG);

    typedef struct packed {
        logic [N_SEG-1:0][WORD_W-1:0] words;
        logic [N_SEG-1:0]             lock;
    } store_t;

    store_t s_d, s_q;

    logic [ADDR_W:0] addr_x, off;
    logic [SEG_IW-1:0] seg;
    logic in_win, at_lock;

    always_comb begin
        addr_x     = {1'b0, addr};
        off        = addr_x - BASE_X;
        seg        = SEG_IW'(off - 1'b1);
        in_win     = (addr_x >= BASE_X) && (addr_x <= LAST_X);
        at_lock    = (addr_x == BASE_X);
        s_d        = s_q;
        err_prog_o = 1'b0;
        err_lock_o = 1'b0;
        if (pgm_stb) begin
            if (!in_win) begin
                err_prog_o = 1'b1;
            end else if (at_lock) begin
                s_d.lock = s_q.lock & data[N_SEG-1:0];
            end else if (!s_q.lock[seg]) begin
                err_prog_o = 1'b1;
                err_lock_o = 1'b1;
            end else begin
                s_d.words[seg] = s_q.words[seg] & data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign words_o = s_q.words;
    assign lock_o  = s_q.lock;

    p_bits_only_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.words & ~$past(s_q.words)) == '0);
    p_lock_only_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lock & ~$past(s_q.lock)) == '0);

    for (genvar g = 0; g < N_SEG; g++) begin : g_hold
        p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !s_q.lock[g] |=> $stable(s_q.words[g]));
    end
endmodule

// File: rtl/otp_status.sv
module otp_status
    import otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       set_prog_i,
    input  logic       set_lock_i,
    output logic [7:0] status_o
);
    typedef struct packed {
        logic prog_err;
        logic lock_err;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) s_d = '0;
        if (set_prog_i) s_d.prog_err = 1'b1;
        if (set_lock_i) s_d.lock_err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        status_o               = '0;
        status_o[BIT_READY]    = 1'b1;
        status_o[BIT_PROG_ERR] = s_q.prog_err;
        status_o[BIT_LOCK_ERR] = s_q.lock_err;
    end

    p_lock_implies_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lock_err |-> s_q.prog_err);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_prog_i) |=> (!s_q.prog_err && !s_q.lock_err));
    p_prog_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_prog_i |=> s_q.prog_err);
endmodule

// File: rtl/otp_read_mux.sv
module otp_read_mux
    import otp_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          WORD_W    = 16,
    parameter int          N_SEG     = 4,
    parameter int unsigned BASE_ADDR = 'h80
) (
    input  view_e                         view,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [N_SEG-1:0][WORD_W-1:0]  words,
    input  logic [N_SEG-1:0]              lock,
    input  logic [7:0]                    status,
    input  logic [WORD_W-1:0]             arr_rdata,
    output logic [WORD_W-1:0]             rdata
);
    localparam int SEG_IW = (N_SEG > 1) ? $clog2(N_SEG) : 1;
    localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] LAST_X = (ADDR_W+1)'(BASE_ADDR + N_SEG);

    logic [ADDR_W:0] addr_x, off;
    logic [SEG_IW-1:0] seg;

    always_comb begin
        addr_x = {1'b0, addr};
        off    = addr_x - BASE_X;
        seg    = SEG_IW'(off - 1'b1);
        rdata  = '0;
        unique case (view)
            VIEW_ARRAY:  rdata = arr_rdata;
            VIEW_STATUS: rdata = {{(WORD_W-8){1'b0}}, status};
            VIEW_PROT: begin
                if (addr_x == BASE_X)
                    rdata = {{(WORD_W-N_SEG){1'b1}}, lock};
                else if (addr_x > BASE_X && addr_x <= LAST_X)
                    rdata = words[seg];
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_prot_reg.sv
module otp_prot_reg
    import otp_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          WORD_W    = 16,
    parameter int          N_SEG     = 4,
    parameter int unsigned BASE_ADDR = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic [WORD_W-1:0] bus_rdata
);
    view_e                        view;
    logic                         pgm_stb, clr_stb, err_prog, err_lock;
    logic [N_SEG-1:0][WORD_W-1:0] words;
    logic [N_SEG-1:0]             lock;
    logic [7:0]                   status;

    otp_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_byte(bus_wdata[7:0]),
        .view_o(view), .pgm_stb_o(pgm_stb), .clr_stb_o(clr_stb)
    );

    otp_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .N_SEG(N_SEG), .BASE_ADDR(BASE_ADDR)) u_store (
        .clk(clk), .rst_n(rst_n), .pgm_stb(pgm_stb), .addr(bus_addr), .data(bus_wdata),
        .words_o(words), .lock_o(lock), .err_prog_o(err_prog), .err_lock_o(err_lock)
    );

    otp_status u_status (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_stb), .set_prog_i(err_prog),
        .set_lock_i(err_lock), .status_o(status)
    );

    otp_read_mux #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .N_SEG(N_SEG), .BASE_ADDR(BASE_ADDR)) u_mux (
        .view(view), .addr(bus_addr), .words(words), .lock(lock), .status(status),
        .arr_rdata(arr_rdata), .rdata(bus_rdata)
    );

    p_no_prog_and_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_stb && clr_stb));
endmodule

// File: tb/otp_prot_reg_test.sv
module otp_prot_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] arr_rdata = 16'hA5C3;
    logic [15:0] bus_rdata;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    otp_prot_reg uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .arr_rdata(arr_rdata), .bus_rdata(bus_rdata)
    );

    // {is_read, req, addr, data, expected}
    localparam int NV = 53;
    localparam logic [44:0] VEC [0:NV-1] = '{
        {1'b1, 4'd1,  8'h81, 16'h0000, 16'hA5C3}, // R1 array view at reset
        {1'b0, 4'd4,  8'h00, 16'h0070, 16'h0000},
        {1'b1, 4'd1,  8'h00, 16'h0000, 16'h0080}, // R1 R4 status 0x80
        {1'b0, 4'd2,  8'h00, 16'h0090, 16'h0000},
        {1'b1, 4'd1,  8'h81, 16'h0000, 16'hFFFF},
        {1'b1, 4'd1,  8'h80, 16'h0000, 16'hFFFF},
        {1'b1, 4'd2,  8'h85, 16'h0000, 16'h0000}, // R2 outside window
        {1'b1, 4'd2,  8'h84, 16'h0000, 16'hFFFF},
        {1'b0, 4'd5,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd5,  8'h82, 16'h1234, 16'h0000},
        {1'b1, 4'd5,  8'h82, 16'h0000, 16'h1234}, // R5
        {1'b0, 4'd5,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd5,  8'h82, 16'h00FF, 16'h0000},
        {1'b1, 4'd5,  8'h82, 16'h0000, 16'h0034}, // R5 AND
        {1'b0, 4'd6,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd6,  8'h83, 16'h0090, 16'h0000},
        {1'b1, 4'd6,  8'h83, 16'h0000, 16'h0090}, // R6 command value as data
        {1'b0, 4'd7,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd7,  8'h86, 16'hABCD, 16'h0000},
        {1'b1, 4'd7,  8'h86, 16'h0000, 16'h0000}, // R7
        {1'b0, 4'd7,  8'h00, 16'h0070, 16'h0000},
        {1'b1, 4'd7,  8'h00, 16'h0000, 16'h0090}, // R7 bit 4
        {1'b0, 4'd7,  8'h00, 16'h0090, 16'h0000},
        {1'b1, 4'd7,  8'h81, 16'h0000, 16'hFFFF},
        {1'b0, 4'd10, 8'h00, 16'h0050, 16'h0000},
        {1'b1, 4'd10, 8'h82, 16'h0000, 16'h0034}, // R10 view kept
        {1'b0, 4'd10, 8'h00, 16'h0070, 16'h0000},
        {1'b1, 4'd10, 8'h00, 16'h0000, 16'h0080}, // R10 cleared
        {1'b0, 4'd9,  8'h00, 16'h0090, 16'h0000},
        {1'b0, 4'd9,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd9,  8'h80, 16'hFFFD, 16'h0000},
        {1'b1, 4'd9,  8'h80, 16'h0000, 16'hFFFD}, // R9 lock seg 1
        {1'b0, 4'd8,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd8,  8'h82, 16'h0000, 16'h0000},
        {1'b1, 4'd8,  8'h82, 16'h0000, 16'h0034}, // R8 unchanged
        {1'b0, 4'd8,  8'h00, 16'h0070, 16'h0000},
        {1'b1, 4'd8,  8'h00, 16'h0000, 16'h0092}, // R8 bits 4 and 1
        {1'b0, 4'd9,  8'h00, 16'h0090, 16'h0000},
        {1'b0, 4'd9,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd9,  8'h81, 16'h5555, 16'h0000},
        {1'b1, 4'd9,  8'h81, 16'h0000, 16'h5555}, // R9 unlocked seg stays open
        {1'b0, 4'd9,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd9,  8'h80, 16'hFFFF, 16'h0000},
        {1'b1, 4'd9,  8'h80, 16'h0000, 16'hFFFD}, // R9 no re-set
        {1'b0, 4'd11, 8'h00, 16'h0033, 16'h0000},
        {1'b1, 4'd11, 8'h81, 16'h0000, 16'h5555}, // R11 ignored
        {1'b0, 4'd3,  8'h00, 16'h00FF, 16'h0000},
        {1'b1, 4'd3,  8'h81, 16'h0000, 16'hA5C3}, // R3
        {1'b0, 4'd6,  8'h00, 16'h00C0, 16'h0000},
        {1'b0, 4'd6,  8'h84, 16'h00FF, 16'h0000},
        {1'b1, 4'd6,  8'h84, 16'h0000, 16'hA5C3}, // R6 array view kept
        {1'b0, 4'd5,  8'h00, 16'h0090, 16'h0000},
        {1'b1, 4'd5,  8'h84, 16'h0000, 16'h00FF}  // R5
    };

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        n_run++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) rd_chk($sformatf("R%0d vec %0d", VEC[i][43:40], i),
                                   VEC[i][39:32], VEC[i][15:0]);
            else wr(VEC[i][39:32], VEC[i][31:16]);
        end
        // R3 array pass-through follows input
        wr(8'h00, 16'h00FF);
        arr_rdata = 16'h1E0F;
        rd_chk("R3 follow", 8'h83, 16'h1E0F);
        // R7 below the window
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h00C0);
        wr(8'h7F, 16'h0000);
        wr(8'h00, 16'h0070);
        rd_chk("R7 below", 8'h00, 16'h0090);
        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1 after reset", 8'h82, 16'h1E0F);
        wr(8'h00, 16'h0090);
        rd_chk("R1 seg reset", 8'h82, 16'hFFFF);
        rd_chk("R1 lock reset", 8'h80, 16'hFFFF);
        wr(8'h00, 16'h0070);
        rd_chk("R1 R4 status reset", 8'h00, 16'h0080);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule